// File: doc/BRIEF.md
# Token Packet Receiver and Checker

This block sits behind a serial bus line decoder that has already undone the line coding and removed the stuffed bits. It sees one decoded bit per qualified cycle, framed by a start marker and an end marker, and assembles the packet that follows the sync pattern. The first eight bits carry a packet identifier. The block checks that identifier for self-consistency. For the four token kinds it also pulls out the device address and endpoint, or the frame number, and checks the 5-bit token CRC.

Results are registered on the cycle that takes the end marker. A good token gives a one-cycle valid pulse. A bad packet raises exactly one error flag instead. The packet kind, the fields and the flags then hold steady until the next start marker. Data payloads and transaction sequencing belong to other blocks.

Top module: `usb_tok_rx`

## Requirements
- R1: After reset, every output is zero.
- R2: A high `pktStart` opens a packet. While a packet is open, a bit is taken on every cycle with `bitValid` high and `pktEnd` low. A high `pktEnd` closes the packet, and the results appear on the outputs at the clock edge that samples it.
- R3: The identifier is bits 0..7 of the packet, least significant bit first. The type is bits 0..3, and bits 4..7 must be the bitwise complement of the type. When at least 8 bits arrived and the complement does not match, `pidErr` is raised.
- R4: Only types 4'b0001, 4'b1001, 4'b0101 and 4'b1101 are tokens. The type 4'b0101 is the frame-marker token. Any other type with a valid identifier raises `notToken`, and its length and CRC are not judged.
- R5: In a token, bits 8..14 are the device address, bits 15..18 the endpoint and bits 19..23 the CRC, each least significant bit first. `frameNum` presents bits 8..18 as one 11-bit number.
- R6: The CRC uses x^5+x^2+1 and covers bits 8..23. The register is preset to all ones before bit 8, and a correct token leaves it holding 5'b01100. A token of the correct length that ends with any other value raises `crcErr`.
- R7: A token whose bit count is not exactly 24 raises `lenErr` and gives no valid pulse. A packet with fewer than 8 bits also raises `lenErr`.
- R8: `tokValid` is high for exactly one cycle and only when no error flag is high. At most one of `pidErr`, `crcErr`, `lenErr` and `notToken` is high at a time.
- R9: `pidType`, `devAddr`, `endPoint`, `frameNum` and the error flags hold their values from the result cycle until the next `pktStart`. A `pktStart` clears the error flags one clock edge later, and the fields stay unchanged until the next result.
- R10: A `pktStart` while a packet is open throws away the bits taken so far and starts a new packet.
- R11: `pktEnd` and `bitValid` have no effect while no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Decoded, destuffed data bit |
| bitValid | input | 1 | `bitIn` carries a bit this cycle |
| pktStart | input | 1 | Start-of-packet marker (one cycle, no bit) |
| pktEnd | input | 1 | End-of-packet marker (one cycle, no bit) |
| pidType | output | 4 | Type nibble of the last packet |
| devAddr | output | 7 | Device address of the last packet |
| endPoint | output | 4 | Endpoint of the last packet |
| frameNum | output | 11 | Frame number of the last packet |
| tokValid | output | 1 | One-cycle pulse for a good token |
| pidErr | output | 1 | Identifier complement check failed |
| crcErr | output | 1 | Token CRC residual wrong |
| lenErr | output | 1 | Token bit count wrong, or identifier incomplete |
| notToken | output | 1 | Valid identifier that is not a token |

## Verification
The hardest case to reach from the ports is a token that is one bit too short or too long yet still has a valid token identifier, because most malformed streams fail the identifier check first. The stimulus builds correct tokens with a bench-side CRC, then adds or drops trailing bits, flips single bits in the CRC-covered span, and inserts idle gaps between bits. A restart in the middle of a packet and an end marker while idle are driven directly, and the outputs are checked before and after each.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;

  localparam int PID_BITS  = 8;
  localparam int ADDR_BITS = 7;
  localparam int EP_BITS   = 4;
  localparam int CRC_BITS  = 5;
  localparam logic [CRC_BITS-1:0] CRC_POLY  = 5'b00101;
  localparam logic [CRC_BITS-1:0] CRC_RESID = 5'b01100;

  typedef enum logic [3:0] {
    TOK_OUT   = 4'b0001,
    TOK_IN    = 4'b1001,
    TOK_FRAME = 4'b0101,
    TOK_SETUP = 4'b1101
  } tokKind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rxState_e;

  typedef struct packed {
    logic clearAll;
    logic takeBit;
    logic finish;
  } rxStrobe_t;

endpackage

// File: rtl/usb_tok_ctl.sv
module usb_tok_ctl
  import usb_tok_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       pktStart,
  input  logic       pktEnd,
  output rxStrobe_t  strobe
);

  rxState_e state;
  rxState_e nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (pktStart) begin
      strobe.clearAll = 1'b1;
      nextState       = ST_RECV;
    end else if (state == ST_RECV) begin
      if (pktEnd) begin
        strobe.finish = 1'b1;
        nextState     = ST_IDLE;
      end else if (bitValid) begin
        strobe.takeBit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R2

  AST_IDLE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !pktStart) |-> (!strobe.takeBit && !strobe.finish)); // R11

  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/usb_tok_dp.sv
module usb_tok_dp
  import usb_tok_pkg::*;
#(
  parameter int PidBits  = PID_BITS,
  parameter int AddrBits = ADDR_BITS,
  parameter int EpBits   = EP_BITS,
  parameter int CrcBits  = CRC_BITS,
  parameter logic [CrcBits-1:0] CrcPoly  = CRC_POLY,
  parameter logic [CrcBits-1:0] CrcResid = CRC_RESID
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        bitIn,
  input  rxStrobe_t                   strobe,
  output logic [PidBits/2-1:0]        pidType,
  output logic [AddrBits-1:0]         devAddr,
  output logic [EpBits-1:0]           endPoint,
  output logic [AddrBits+EpBits-1:0]  frameNum,
  output logic                        tokValid,
  output logic                        pidErr,
  output logic                        crcErr,
  output logic                        lenErr,
  output logic                        notToken
);

  localparam int NIB      = PidBits / 2;
  localparam int FRM_BITS = AddrBits + EpBits;
  localparam int CAP_BITS = PidBits + FRM_BITS;
  localparam int TOK_BITS = CAP_BITS + CrcBits;
  localparam int CNT_W    = $clog2(TOK_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_PID = CNT_W'(PidBits);
  localparam logic [CNT_W-1:0] CNT_TOK = CNT_W'(TOK_BITS);

  logic [CNT_W-1:0]    bitCnt;
  logic [CAP_BITS-1:0] capReg;
  logic [CrcBits-1:0]  crcReg;

  // capture, count and CRC
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      capReg <= '0;
      crcReg <= '1;
    end else if (strobe.clearAll) begin
      bitCnt <= '0;
      capReg <= '0;
      crcReg <= '1;
    end else if (strobe.takeBit) begin
      if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      for (int i = 0; i < CAP_BITS; i++) begin
        if (bitCnt == CNT_W'(i)) capReg[i] <= bitIn;
      end
      if (bitCnt >= CNT_PID && bitCnt < CNT_TOK) begin
        crcReg <= {crcReg[CrcBits-2:0], 1'b0}
                  ^ ((bitIn ^ crcReg[CrcBits-1]) ? CrcPoly : '0);
      end
    end
  end

  // verdict
  logic [NIB-1:0] typeNib;
  logic [NIB-1:0] chkNib;
  logic           pidFull;
  logic           pidOk;
  logic           isTok;
  logic           lenOk;
  logic           crcOk;
  logic           vPidErr, vCrcErr, vLenErr, vNotTok, vValid;

  assign typeNib = capReg[NIB-1:0];
  assign chkNib  = capReg[PidBits-1:NIB];
  assign pidFull = (bitCnt >= CNT_PID);
  assign pidOk   = pidFull && (chkNib == ~typeNib);
  assign lenOk   = (bitCnt == CNT_TOK);
  assign crcOk   = (crcReg == CrcResid);

  always_comb begin
    case (typeNib)
      TOK_OUT, TOK_IN, TOK_FRAME, TOK_SETUP: isTok = 1'b1;
      default:                               isTok = 1'b0;
    endcase
  end

  always_comb begin
    vPidErr = pidFull && !pidOk;
    vNotTok = pidOk && !isTok;
    vLenErr = !pidFull || (pidOk && isTok && !lenOk);
    vCrcErr = pidOk && isTok && lenOk && !crcOk;
    vValid  = pidOk && isTok && lenOk && crcOk;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tokValid <= 1'b0;
      pidErr   <= 1'b0;
      crcErr   <= 1'b0;
      lenErr   <= 1'b0;
      notToken <= 1'b0;
      pidType  <= '0;
      devAddr  <= '0;
      endPoint <= '0;
      frameNum <= '0;
    end else if (strobe.clearAll) begin
      tokValid <= 1'b0;
      pidErr   <= 1'b0;
      crcErr   <= 1'b0;
      lenErr   <= 1'b0;
      notToken <= 1'b0;
    end else if (strobe.finish) begin
      tokValid <= vValid;
      pidErr   <= vPidErr;
      crcErr   <= vCrcErr;
      lenErr   <= vLenErr;
      notToken <= vNotTok;
      pidType  <= typeNib;
      devAddr  <= capReg[PidBits +: AddrBits];
      endPoint <= capReg[PidBits + AddrBits +: EpBits];
      frameNum <= capReg[PidBits +: FRM_BITS];
    end else begin
      tokValid <= 1'b0;
    end
  end

  AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    tokValid |-> !(pidErr || crcErr || lenErr || notToken)); // R8

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pidErr, crcErr, lenErr, notToken})); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    tokValid |=> !tokValid); // R8

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable({pidType, devAddr, endPoint, frameNum})); // R9

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> !(pidErr || crcErr || lenErr || notToken || tokValid)); // R9

  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt <= CNT_PID) |-> (crcReg == '1)); // R6

  AST_LEN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tokValid) |-> ($past(bitCnt) == CNT_TOK)); // R7

endmodule

// File: rtl/usb_tok_rx.sv
module usb_tok_rx
  import usb_tok_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitIn,
  input  logic        bitValid,
  input  logic        pktStart,
  input  logic        pktEnd,
  output logic [3:0]  pidType,
  output logic [6:0]  devAddr,
  output logic [3:0]  endPoint,
  output logic [10:0] frameNum,
  output logic        tokValid,
  output logic        pidErr,
  output logic        crcErr,
  output logic        lenErr,
  output logic        notToken
);

  rxStrobe_t strobe;

  usb_tok_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .pktStart (pktStart),
    .pktEnd   (pktEnd),
    .strobe   (strobe)
  );

  usb_tok_dp #(
    .PidBits  (PID_BITS),
    .AddrBits (ADDR_BITS),
    .EpBits   (EP_BITS),
    .CrcBits  (CRC_BITS),
    .CrcPoly  (CRC_POLY),
    .CrcResid (CRC_RESID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bitIn    (bitIn),
    .strobe   (strobe),
    .pidType  (pidType),
    .devAddr  (devAddr),
    .endPoint (endPoint),
    .frameNum (frameNum),
    .tokValid (tokValid),
    .pidErr   (pidErr),
    .crcErr   (crcErr),
    .lenErr   (lenErr),
    .notToken (notToken)
  );

endmodule

// File: tb/test_usb_tok_rx.sv
module test_usb_tok_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitIn = 1'b0;
  logic        bitValid = 1'b0;
  logic        pktStart = 1'b0;
  logic        pktEnd = 1'b0;
  logic [3:0]  pidType;
  logic [6:0]  devAddr;
  logic [3:0]  endPoint;
  logic [10:0] frameNum;
  logic        tokValid, pidErr, crcErr, lenErr, notToken;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  usb_tok_rx i_usb_tok_rx (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .pktStart(pktStart), .pktEnd(pktEnd), .pidType(pidType),
    .devAddr(devAddr), .endPoint(endPoint), .frameNum(frameNum),
    .tokValid(tokValid), .pidErr(pidErr), .crcErr(crcErr),
    .lenErr(lenErr), .notToken(notToken)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // CRC field for an 11-bit payload, LSB-first field order
  function automatic logic [4:0] crcField(input logic [10:0] d);
    logic [4:0] c = 5'b11111;
    logic [4:0] f;
    for (int i = 0; i < 11; i++) begin
      logic fb = d[i] ^ c[4];
      c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    for (int i = 0; i < 5; i++) f[i] = ~c[4 - i];
    return f;
  endfunction

  function automatic logic [31:0] mkTok(input logic [3:0] t, input logic [10:0] d);
    return {8'h00, crcField(d), d, ~t, t};
  endfunction

  function automatic bit isTokType(input logic [3:0] t);
    return (t == 4'b0001) || (t == 4'b1001) || (t == 4'b0101) || (t == 4'b1101);
  endfunction

  task automatic sendPkt(input logic [31:0] bits, input int n, input bit gaps);
    @(negedge clk);
    pktStart = 1'b1; bitValid = 1'b0;
    @(negedge clk);
    pktStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        bitValid = 1'b0; bitIn = $urandom % 2;
        @(negedge clk);
      end
      bitValid = 1'b1; bitIn = bits[i];
      @(negedge clk);
    end
    bitValid = 1'b0; pktEnd = 1'b1;
    @(negedge clk);
    pktEnd = 1'b0;
  endtask

  // outputs are sampled on the negedge right after the result edge
  task automatic checkPkt(input logic [31:0] bits, input int n, input string tag);
    bit full = (n >= 8);
    bit pOk  = full && (bits[7:4] == ~bits[3:0]);
    bit tok  = pOk && isTokType(bits[3:0]);
    bit eP   = full && !pOk;
    bit eN   = pOk && !tok;
    bit eL   = !full || (tok && n != 24);
    bit eC   = tok && n == 24 && (crcField(bits[18:8]) != bits[23:19]);
    bit eV   = tok && n == 24 && !eC;
    logic [10:0] sFrm;
    logic [3:0]  sTyp;
    chk(tokValid == eV, "R8", {tag, " tokValid"}, tokValid, eV);
    chk(pidErr == eP, "R3", {tag, " pidErr"}, pidErr, eP);
    chk(notToken == eN, "R4", {tag, " notToken"}, notToken, eN);
    chk(lenErr == eL, "R7", {tag, " lenErr"}, lenErr, eL);
    chk(crcErr == eC, "R6", {tag, " crcErr"}, crcErr, eC);
    if (eV) begin
      chk(pidType == bits[3:0], "R5", {tag, " pidType"}, pidType, bits[3:0]);
      chk(devAddr == bits[14:8], "R5", {tag, " devAddr"}, devAddr, bits[14:8]);
      chk(endPoint == bits[18:15], "R5", {tag, " endPoint"}, endPoint, bits[18:15]);
      chk(frameNum == bits[18:8], "R5", {tag, " frameNum"}, frameNum, bits[18:8]);
    end
    sFrm = frameNum; sTyp = pidType;
    @(negedge clk);
    chk(tokValid == 1'b0, "R8", {tag, " pulse width"}, tokValid, 0);
    chk(frameNum == sFrm && pidType == sTyp, "R9", {tag, " fields hold"}, frameNum, sFrm);
    chk({pidErr, crcErr, lenErr, notToken} == {eP, eC, eL, eN}, "R9", {tag, " flags hold"},
        {pidErr, crcErr, lenErr, notToken}, {eP, eC, eL, eN});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] pk;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({pidType, devAddr, endPoint, frameNum, tokValid, pidErr, crcErr, lenErr, notToken} == '0,
        "R1", "reset outputs", frameNum, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5 each token kind, clean
    pk = mkTok(4'b0001, 11'h3A5); sendPkt(pk, 24, 0); checkPkt(pk, 24, "R4 out");
    pk = mkTok(4'b1001, 11'h07F); sendPkt(pk, 24, 1); checkPkt(pk, 24, "R4 in");
    pk = mkTok(4'b0101, 11'h7FF); sendPkt(pk, 24, 0); checkPkt(pk, 24, "R5 frame");
    pk = mkTok(4'b1101, 11'h000); sendPkt(pk, 24, 1); checkPkt(pk, 24, "R5 setup");

    // R4 valid non-token identifier
    pk = mkTok(4'b0011, 11'h123); sendPkt(pk, 24, 0); checkPkt(pk, 24, "R4 data");
    // R3 bad complement
    pk = mkTok(4'b1001, 11'h155); pk[6] = ~pk[6]; sendPkt(pk, 24, 0); checkPkt(pk, 24, "R3 pid");
    // R6 single flipped CRC bit
    pk = mkTok(4'b0001, 11'h2C3); pk[21] = ~pk[21]; sendPkt(pk, 24, 0); checkPkt(pk, 24, "R6 crc");
    // R7 length corners
    pk = mkTok(4'b1101, 11'h456); sendPkt(pk, 23, 0); checkPkt(pk, 23, "R7 short");
    pk = mkTok(4'b1101, 11'h456); sendPkt(pk, 25, 0); checkPkt(pk, 25, "R7 long");
    sendPkt(32'h0, 0, 0); checkPkt(32'h0, 0, "R7 empty");
    pk = mkTok(4'b1001, 11'h456); sendPkt(pk, 7, 0); checkPkt(pk, 7, "R7 pid short");

    // R11 end marker and bits while idle
    pk = mkTok(4'b1001, 11'h5A5); sendPkt(pk, 24, 0); checkPkt(pk, 24, "R11 setup");
    bitValid = 1'b1; bitIn = 1'b1; @(negedge clk);
    bitValid = 1'b0; pktEnd = 1'b1; @(negedge clk);
    pktEnd = 1'b0; @(negedge clk);
    chk(tokValid == 1'b0 && devAddr == pk[14:8] && lenErr == 1'b0, "R11", "idle end ignored",
        devAddr, pk[14:8]);

    // R10 restart mid-packet
    @(negedge clk); pktStart = 1'b1; @(negedge clk); pktStart = 1'b0;
    for (int i = 0; i < 13; i++) begin bitValid = 1'b1; bitIn = 1'b1; @(negedge clk); end
    bitValid = 1'b0;
    pk = mkTok(4'b0101, 11'h321); sendPkt(pk, 24, 0); checkPkt(pk, 24, "R10 restart");

    // R9 start clears flags, fields kept
    pk = mkTok(4'b0001, 11'h111); pk[20] = ~pk[20]; sendPkt(pk, 24, 0); checkPkt(pk, 24, "R9 crc");
    pktStart = 1'b1; @(negedge clk); pktStart = 1'b0;
    chk(crcErr == 1'b0 && frameNum == pk[18:8], "R9", "start clears flag", crcErr, 0);
    pktEnd = 1'b1; @(negedge clk); pktEnd = 1'b0; @(negedge clk);

    // R2 random mix with gaps
    for (int it = 0; it < 120; it++) begin
      int mode = $urandom % 5;
      int n = 24;
      logic [3:0] t = isTokType(4'($urandom)) ? 4'($urandom) : 4'b0001;
      pk = mkTok((mode == 4) ? 4'($urandom) : t, 11'($urandom));
      pk[31:24] = 8'($urandom);
      case (mode)
        1: pk[$urandom % 8] ^= 1'b1;
        2: pk[8 + ($urandom % 16)] ^= 1'b1;
        3: n = ($urandom % 2) ? 24 + 1 + ($urandom % 4) : 24 - 1 - ($urandom % 4);
        default: ;
      endcase
      sendPkt(pk, n, 1);
      checkPkt(pk, n, "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule